// File: doc/BRIEF.md
# Line-Detect and Handshake Clamp Controller

This block sits between a modem's analog front end and its terminal-side control lines. It uses two comparator flags to decide when the received-line-signal-detect output should turn on and off. One flag says the received level is above the turn-on threshold. The other says it is below the turn-off threshold. Each change needs the qualifying condition to persist for a programmable number of millisecond ticks. The gap between the two thresholds gives hysteresis: while neither flag is set, the detect output keeps its state.

The block also echoes request-to-send onto clear-to-send, but only once the training sequence has finished. While the local transmitter is requesting the line, received data is forced to binary one and detect is forced off. An optional hold keeps that clamp in place for a further programmable number of ticks after request-to-send drops, so that line echo cannot appear as data.

The received-data path is a level: one bit per clock with no valid/ready pair. It is gated combinationally and never applies back-pressure. All other pins are plain control and status. Energy measurement is done outside the block.

Top module: `cdet_clamp_ctrl`

## Requirements
- R1: While reset is asserted, and directly after reset, `dcd` and `cts` are 0. With `rts` low, `rx_out` equals `rx_in`.
- R2: `cts` becomes 1 one clock after `rts` and `train_done` are both 1. It becomes 0 one clock after either of them is 0. It is never 1 unless both were 1 on the previous clock.
- R3: With `dcd` off and no clamp, `dcd` turns on at the edge that takes the ON_MS-th `ms_tick` seen while `lvl_above_on` has been held without a break. Any clock with `lvl_above_on` low restarts that count from zero.
- R4: With `dcd` on, it turns off at the edge that takes the OFF_MS-th `ms_tick` seen while `lvl_below_off` has been held without a break. Any clock with `lvl_below_off` low restarts that count.
- R5: While neither comparator flag is set, `dcd` keeps its current value, whether that value is on or off.
- R6: While `rts` is 1, and on the clock after it falls, `rx_out` is 1 and `dcd` is 0. This takes effect in the same cycle that `rts` rises.
- R7: With HOLD_EN=1, the clamp of R6 stays in force after `rts` falls until HOLD_MS further ticks have been taken. After that, `rx_out` follows `rx_in` again.
- R8: A clamp leaves detection in the off state. After the clamp ends, a full ON_MS tick count is needed before `dcd` turns on, and ticks taken during the clamp do not count toward it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| lvl_above_on | input | 1 | Received level above the turn-on threshold |
| lvl_below_off | input | 1 | Received level below the turn-off threshold |
| rts | input | 1 | Request to send from the terminal |
| train_done | input | 1 | Transmit training sequence finished |
| rx_in | input | 1 | Demodulated receive data |
| dcd | output | 1 | Received line signal detect |
| cts | output | 1 | Ready for sending |
| rx_out | output | 1 | Clamped receive data |

## Verification
The clamp (R6) acts combinationally, so the bench checks `rx_out` and `dcd` half a cycle after it drives `rts`. `cts` is a single register (R2), so it is checked one rising edge after the inputs change. The detect and hold timers move only on an edge that takes a tick (R3, R4, R7, R8). Each tick is driven as one pulse between two falling edges, and the output is sampled at the next falling edge. The bench can therefore state the exact tick count at which each transition is due, and it checks the count just below that one as well as the count itself.

// File: rtl/cdet_pkg.sv
package cdet_pkg;
  // Counter width able to hold values 0..lim
  function automatic int cnt_width(input int lim);
    int w;
    w = $clog2(lim + 1);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/cdet_tick_timer.sv
module cdet_tick_timer #(
  parameter int LIM = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic fire
);
  localparam int CW = cdet_pkg::cnt_width(LIM);
  localparam logic [CW-1:0] LAST = CW'(LIM - 1);

  logic [CW-1:0] cnt;

  assign fire = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick) cnt <= fire ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/cdet_hold_timer.sv
module cdet_hold_timer #(
  parameter int HOLD_MS = 150,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  input  logic tick,
  output logic active
);
  localparam int CW = cdet_pkg::cnt_width(HOLD_MS);

  generate
    if (HOLD_EN && HOLD_MS > 0) begin : g_hold
      logic [CW-1:0] left;
      always_ff @(posedge clk) begin
        if (!rst_n || cancel) left <= '0;
        else if (start) left <= CW'(HOLD_MS);
        else if (tick && left != '0) left <= left - 1'b1;
      end
      assign active = (left != '0);
    end else begin : g_nohold
      assign active = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cdet_clamp_ctrl.sv
module cdet_clamp_ctrl #(
  parameter int ON_MS   = 100,
  parameter int OFF_MS  = 40,
  parameter int HOLD_MS = 150,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic lvl_above_on,
  input  logic lvl_below_off,
  input  logic rts,
  input  logic train_done,
  input  logic rx_in,
  output logic dcd,
  output logic cts,
  output logic rx_out
);
  logic rts_q, det, cts_q;
  logic hold_act, clamp;
  logic on_fire, off_fire;

  assign clamp = rts || rts_q || hold_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rts_q <= 1'b0;
      cts_q <= 1'b0;
    end else begin
      rts_q <= rts;
      cts_q <= rts && train_done;
    end
  end

  cdet_hold_timer #(.HOLD_MS(HOLD_MS), .HOLD_EN(HOLD_EN)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .start(rts_q && !rts), .cancel(rts),
    .tick(ms_tick), .active(hold_act)
  );

  cdet_tick_timer #(.LIM(ON_MS)) u_on (
    .clk(clk), .rst_n(rst_n),
    .run(!det && lvl_above_on && !clamp),
    .tick(ms_tick), .fire(on_fire)
  );

  cdet_tick_timer #(.LIM(OFF_MS)) u_off (
    .clk(clk), .rst_n(rst_n),
    .run(det && lvl_below_off && !clamp),
    .tick(ms_tick), .fire(off_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clamp) det <= 1'b0;
    else if (!det && on_fire) det <= 1'b1;
    else if (det && off_fire) det <= 1'b0;
  end

  assign dcd    = det && !clamp;
  assign cts    = cts_q;
  assign rx_out = clamp ? 1'b1 : rx_in;
endmodule

// File: rtl/cdet_clamp_chk.sv
module cdet_clamp_chk (
  input logic clk,
  input logic rst_n,
  input logic lvl_above_on,
  input logic lvl_below_off,
  input logic rts,
  input logic train_done,
  input logic dcd,
  input logic cts,
  input logic rx_out
);
  a_r6_clamp_active: assert property (@(posedge clk) disable iff (!rst_n)
    rts |-> (rx_out && !dcd));
  a_r2_cts_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts) |-> $past(rts && train_done));
  a_r2_cts_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts) |=> !cts);
  a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dcd) |-> $past(lvl_above_on));
  a_r4_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dcd) |-> (rts || $past(lvl_below_off) || $past(rts)));
  a_r6_fall_edge_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> (rx_out && !dcd));
endmodule

bind cdet_clamp_ctrl cdet_clamp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lvl_above_on(lvl_above_on),
  .lvl_below_off(lvl_below_off), .rts(rts), .train_done(train_done),
  .dcd(dcd), .cts(cts), .rx_out(rx_out)
);

// File: tb/sim_cdet_clamp_ctrl.sv
module sim_cdet_clamp_ctrl;
  localparam int ON_MS = 5, OFF_MS = 3, HOLD_MS = 4;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
  logic above = 1'b0, below = 1'b0, rts = 1'b0, train_done = 1'b0, rx_in = 1'b0;
  logic dcd, cts, rx_out;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cdet_clamp_ctrl #(.ON_MS(ON_MS), .OFF_MS(OFF_MS), .HOLD_MS(HOLD_MS), .HOLD_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .lvl_above_on(above),
    .lvl_below_off(below), .rts(rts), .train_done(train_done), .rx_in(rx_in),
    .dcd(dcd), .cts(cts), .rx_out(rx_out));

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick1();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dcd in reset", dcd, 1'b0);
    chk("R1 cts in reset", cts, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dcd after reset", dcd, 1'b0);
    chk("R1 cts after reset", cts, 1'b0);
    rx_in = 1'b1; #1 chk("R1 rx pass 1", rx_out, 1'b1);
    rx_in = 1'b0; #1 chk("R1 rx pass 0", rx_out, 1'b0);

    // R3: a break in the flag restarts the count
    @(negedge clk) above = 1'b1;
    ticks(ON_MS - 1);
    @(negedge clk) above = 1'b0;
    tick1();
    above = 1'b1;
    ticks(ON_MS - 1);
    chk("R3 restart after break", dcd, 1'b0);
    // R3: sweep of tick count
    above = 1'b0; @(negedge clk);
    above = 1'b1;
    for (int k = 1; k <= ON_MS + 2; k++) begin
      tick1();
      chk("R3 on count sweep", dcd, (k >= ON_MS));
    end
    // R5: between thresholds, stays on
    above = 1'b0;
    ticks(3 * OFF_MS);
    chk("R5 hold on", dcd, 1'b1);
    // R4: break restarts
    below = 1'b1;
    ticks(OFF_MS - 1);
    @(negedge clk) below = 1'b0;
    tick1();
    below = 1'b1;
    ticks(OFF_MS - 1);
    chk("R4 restart after break", dcd, 1'b1);
    below = 1'b0; @(negedge clk);
    below = 1'b1;
    for (int k = 1; k <= OFF_MS + 2; k++) begin
      tick1();
      chk("R4 off count sweep", dcd, !(k >= OFF_MS));
    end
    below = 1'b0;
    ticks(2 * ON_MS);
    chk("R5 hold off", dcd, 1'b0);

    // bring detect on for the clamp tests
    above = 1'b1; ticks(ON_MS);
    chk("R3 on again", dcd, 1'b1);

    // R6 / R2
    rx_in = 1'b0;
    @(negedge clk) rts = 1'b1; #1;
    chk("R6 dcd forced off", dcd, 1'b0);
    chk("R6 rx forced one", rx_out, 1'b1);
    repeat (3) @(negedge clk);
    chk("R2 cts needs training", cts, 1'b0);
    train_done = 1'b1; @(negedge clk);
    chk("R2 cts rises", cts, 1'b1);
    train_done = 1'b0; @(negedge clk);
    chk("R2 cts drops on training low", cts, 1'b0);
    train_done = 1'b1; @(negedge clk);
    chk("R2 cts back", cts, 1'b1);
    ticks(2);
    chk("R6 clamp with ticks", rx_out, 1'b1);
    rts = 1'b0; #1;
    chk("R6 clamp on fall cycle", rx_out, 1'b1);
    @(negedge clk);
    chk("R2 cts follows rts low", cts, 1'b0);
    // R7 hold
    for (int k = 1; k <= HOLD_MS; k++) begin
      tick1();
      chk("R7 hold window", rx_out, (k >= HOLD_MS) ? 1'b0 : 1'b1);
      chk("R7 dcd off in hold", dcd, 1'b0);
    end
    // R8 full restart after clamp
    for (int k = 1; k <= ON_MS; k++) begin
      tick1();
      chk("R8 on after clamp", dcd, (k >= ON_MS));
    end
    rx_in = 1'b1; #1 chk("R7 rx follows after hold", rx_out, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule